// File: doc/BRIEF.md
# DAC Output Update Controller

This block decides when a value written into a DAC data register is passed on to the converter core. A bus write fills a holding register. A separate core latch then drives the converter. A two-bit load-select input picks the update trigger. In direct mode the core follows the holding register with no delay. In the other three modes the core is loaded by a completed write or by a rising edge on one of two timer trigger inputs, and only while the conversion-enable input is high.

Writing data first and then firing a timer trigger lets several converters change their outputs together on one timer event. The register writes for each converter can arrive at any time before that event. The trigger inputs can go through an optional synchronizer of `SYNC_STAGES` flops, or be used directly when `SYNC_STAGES` is 0.

Top module: `dac_update_ctrl`

## Requirements
- R1: With load_sel = 0 (direct mode), core_data equals the last written value from the first clock edge that samples wr_en high, with no extra cycle.
- R2: In direct mode, conv_en has no effect. Writes reach core_data whether conv_en is high or low.
- R3: With load_sel = 1 (write mode), a write sampled at edge k is loaded into the core at edge k+1, provided load_sel = 1 and conv_en = 1 at edge k+1. Between edges k and k+1, core_data keeps its old value.
- R4: With load_sel = 2 (trigger A mode), a rising edge on trig_a loads the holding register into the core. core_data changes within SYNC_STAGES + 2 edges after trig_a is first sampled high, and does not change at the first of those edges.
- R5: With load_sel = 3 (trigger B mode), a rising edge on trig_b loads the core. In mode 3, edges on trig_a have no effect, and in mode 2, edges on trig_b have no effect.
- R6: With load_sel nonzero and conv_en low, core_data holds its value through writes and trigger edges.
- R7: If the holding register is written several times before a trigger, the trigger loads only the most recent value.
- R8: After reset, core_data is zero.
- R9: Changing load_sel between nonzero values never loads the core. Switching to direct mode makes core_data equal the holding register at once.
- R10: A trigger held high loads the core once. Only a new low-to-high transition loads the core again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Value written to the holding register |
| wr_en | input | 1 | Write strobe for the holding register |
| load_sel | input | 2 | Update trigger: 0 direct, 1 write, 2 trigger A, 3 trigger B |
| conv_en | input | 1 | Allows triggered loads in modes 1 to 3 |
| trig_a | input | 1 | Timer trigger input A |
| trig_b | input | 1 | Timer trigger input B |
| core_data | output | DATA_W | Value presented to the converter core |

## Verification
The bench goes after the cycle in which a write-mode load lands. A design that loads on the strobe edge itself would show the stale value, and one that waits longer would miss the check at edge k+1. The bench also writes several times before a trigger, holds a trigger high across several cycles, and fires the trigger that the current mode does not select. A level-sensitive detector would reload on every cycle, and a missing mode decode would let the wrong timer update the core. A design that leaves the enable gate active in direct mode, or that loads when load_sel moves between nonzero modes, would show a core value that differs from the value the bench expects.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
   typedef enum logic [1:0] {
      LD_DIRECT   = 2'd0,
      LD_ON_WRITE = 2'd1,
      LD_TRIG_A   = 2'd2,
      LD_TRIG_B   = 2'd3
   } load_mode_e;
endpackage

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] data_q,
   output logic              wr_seen
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         wr_seen <= 1'b0;
      end else begin
         wr_seen <= wr_en;
         if (wr_en) data_q <= wr_data;
      end
   end

   // latest write wins in the holding register
   p_latest_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> data_q == $past(wr_data));
endmodule

// File: rtl/dac_trig_edge.sv
module dac_trig_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise
);
   logic lvl;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = trig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q <= '0;
               else        sr_q <= trig_in;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q <= '0;
               else        sr_q <= {sr_q[SYNC_STAGES-2:0], trig_in};
            end
         end
         assign lvl = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

   // a held level yields one pulse only
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/dac_core_latch.sv
module dac_core_latch
   import dac_upd_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  load_mode_e        mode,
   input  logic              conv_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] data_q,
   input  logic              wr_seen,
   input  logic              rise_a,
   input  logic              rise_b,
   output logic [DATA_W-1:0] core_data
);
   logic [DATA_W-1:0] latch_q;
   logic              load_now;

   always_comb begin
      unique case (mode)
         LD_ON_WRITE: load_now = wr_seen & conv_en;
         LD_TRIG_A:   load_now = rise_a  & conv_en;
         LD_TRIG_B:   load_now = rise_b  & conv_en;
         default:     load_now = 1'b0;
      endcase
   end

   // direct mode keeps the latch tracking so leaving it causes no jump
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                latch_q <= '0;
      else if (mode == LD_DIRECT) latch_q <= wr_en ? wr_data : data_q;
      else if (load_now)          latch_q <= data_q;
   end

   assign core_data = (mode == LD_DIRECT) ? data_q : latch_q;

   p_direct_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LD_DIRECT && $past(mode) == LD_DIRECT && $past(wr_en))
      |-> core_data == $past(wr_data));

   p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en, 2) && $past(mode) == LD_ON_WRITE && mode == LD_ON_WRITE && $past(conv_en))
      |-> core_data == $past(wr_data, 2));

   p_trig_a_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_a && mode == LD_TRIG_A && conv_en)
      |=> (mode == LD_DIRECT || core_data == $past(data_q)));

   p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != LD_DIRECT && $past(mode) != LD_DIRECT && !$past(conv_en))
      |-> $stable(core_data));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
   import dac_upd_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic [1:0]        load_sel,
   input  logic              conv_en,
   input  logic              trig_a,
   input  logic              trig_b,
   output logic [DATA_W-1:0] core_data
);
   localparam int NUM_TRIG = 2;

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("dac_update_ctrl: DATA_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("dac_update_ctrl: SYNC_STAGES out of range");
      end
   endgenerate

   logic [DATA_W-1:0]   data_q;
   logic                wr_seen;
   logic [NUM_TRIG-1:0] trig_vec;
   logic [NUM_TRIG-1:0] rise_vec;

   assign trig_vec = {trig_b, trig_a};

   dac_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .data_q  (data_q),
      .wr_seen (wr_seen)
   );

   generate
      for (genvar i = 0; i < NUM_TRIG; i++) begin : g_edge
         dac_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_in (trig_vec[i]),
            .rise    (rise_vec[i])
         );
      end
   endgenerate

   dac_core_latch #(.DATA_W(DATA_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (load_mode_e'(load_sel)),
      .conv_en   (conv_en),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .data_q    (data_q),
      .wr_seen   (wr_seen),
      .rise_a    (rise_vec[0]),
      .rise_b    (rise_vec[1]),
      .core_data (core_data)
   );
endmodule

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
   localparam int W    = 12;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_en = 1'b0;
   logic [1:0]   load_sel = 2'd0;
   logic         conv_en = 1'b0;
   logic         trig_a = 1'b0;
   logic         trig_b = 1'b0;
   logic [W-1:0] core_data;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_reg = '0;
   logic [W-1:0] m_latch = '0;

   always #5 clk = ~clk;

   dac_update_ctrl #(.DATA_W(W), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
      .load_sel(load_sel), .conv_en(conv_en), .trig_a(trig_a),
      .trig_b(trig_b), .core_data(core_data)
   );

   function automatic logic [W-1:0] expect_out();
      return (load_sel == 2'd0) ? m_reg : m_latch;
   endfunction

   task automatic check(string req, logic [W-1:0] exp);
      checks++;
      if (core_data !== exp) begin
         errors++;
         $display("FAIL %s: core_data=%h expected=%h", req, core_data, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(logic [W-1:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
      m_reg = v;
      if (load_sel == 2'd0) m_latch = v;
      else if (load_sel == 2'd1 && conv_en) m_latch = v;
      idle(3);
   endtask

   task automatic pulse(int which, int hold);
      @(negedge clk);
      if (which == 0) trig_a = 1'b1; else trig_b = 1'b1;
      idle(hold);
      trig_a = 1'b0; trig_b = 1'b0;
      if (conv_en && load_sel == 2'(which + 2)) m_latch = m_reg;
      idle(SYNC + 3);
   endtask

   task automatic set_mode(logic [1:0] m);
      @(negedge clk); load_sel = m;
      if (m == 2'd0) m_latch = m_reg;
      #1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed));
      idle(2);
      check("R8 reset", '0);
      rst_n = 1'b1;
      idle(1);
      check("R8 after release", '0);

      // R1 / R2: direct mode, enable low
      conv_en = 1'b0;
      @(negedge clk); wr_en = 1'b1; wr_data = 12'h3A5;
      @(negedge clk); wr_en = 1'b0; m_reg = 12'h3A5; m_latch = m_reg;
      check("R1 direct same cycle", 12'h3A5);
      check("R2 direct ignores enable", 12'h3A5);

      // R3: write mode timing
      set_mode(2'd1); conv_en = 1'b1;
      @(negedge clk); wr_en = 1'b1; wr_data = 12'h7C1;
      @(negedge clk); wr_en = 1'b0;
      check("R3 not yet loaded", 12'h3A5);
      @(negedge clk);
      check("R3 loaded next edge", 12'h7C1);
      m_reg = 12'h7C1; m_latch = m_reg;

      // R6: enable low in write mode
      conv_en = 1'b0;
      do_write(12'h111);
      check("R6 write mode held", 12'h7C1);

      // R4 / R7: trigger A, several writes
      set_mode(2'd2); conv_en = 1'b1;
      do_write(12'h222); do_write(12'h333); do_write(12'h444);
      check("R4 no load before edge", 12'h7C1);
      @(negedge clk); trig_a = 1'b1;
      @(negedge clk);
      check("R4 not at first edge", 12'h7C1);
      idle(SYNC + 1);
      check("R7 latest value loaded", 12'h444);
      m_latch = 12'h444;

      // R10: held high, write, no reload
      do_write(12'h555);
      check("R10 held trigger no reload", 12'h444);
      trig_a = 1'b0; idle(SYNC + 2);

      // R5: trigger B ignored in mode 2, A ignored in mode 3
      pulse(1, 2);
      check("R5 trig_b ignored in mode 2", 12'h444);
      set_mode(2'd3);
      pulse(0, 2);
      check("R5 trig_a ignored in mode 3", 12'h444);
      pulse(1, 2);
      check("R5 trig_b loads in mode 3", 12'h555);

      // R6: enable low in trigger mode
      do_write(12'h666); conv_en = 1'b0;
      pulse(1, 2);
      check("R6 trigger held off", 12'h555);

      // R9: mode changes
      conv_en = 1'b1;
      set_mode(2'd1);
      check("R9 nonzero switch no load", 12'h555);
      set_mode(2'd2);
      check("R9 nonzero switch no load 2", 12'h555);
      set_mode(2'd0);
      check("R9 entering direct follows", 12'h666);
      set_mode(2'd3);
      check("R9 leaving direct keeps value", 12'h666);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 4)       do_write(W'($urandom));
         else if (op < 7)  pulse(int'($urandom_range(0, 1)), int'($urandom_range(1, 4)));
         else if (op < 9)  set_mode(2'($urandom_range(0, 3)));
         else begin @(negedge clk); conv_en = 1'($urandom); end
         check("R1-mix R3 R4 R5 R6 random", expect_out());
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule